// File: doc/BRIEF.md
# Pause Capability Resolver

This block settles which pause-frame directions a full-duplex Ethernet port uses once autonegotiation has finished. Two things are combinational. From the requested mode it produces the symmetric and asymmetric pause bits that the local side advertises. It also flags requests that cannot be honoured. A receive-only request has no advertisement of its own, so it is advertised as full symmetric pause. The transmit direction is then dropped when the result is resolved.

When the resolve strobe is pulsed, the block compares the local advertisement word with the link partner's word. It registers the resolved mode and drives one enable for receive-pause handling and one for transmit-pause generation. An all-zero word on either side is a failed negotiation. In that case an error flag is raised and the previous mode is kept. The width of the advertisement words and the positions of the two pause bits are parameters.

Top module: `pause_resolver`

## Requirements
- R1: Request codes are 0 none, 1 receive-only, 2 transmit-only, 3 full and 4 default. The advertisement is asymmetric only for code 2, both bits for codes 1, 3 and 4, and neither bit for code 0.
- R2: Code 1 with the strict-standard flag set raises `req_err_o` and advertises neither bit. Code 1 without the flag is accepted.
- R3: Code 4 behaves exactly like code 3, both in what it advertises and in how it resolves. Codes 5 to 7 raise `req_err_o` and advertise neither bit.
- R4: On a strobe where either advertisement word is all zeros, `neg_err_o` becomes 1 and the mode keeps its previous value. A strobe with both words non-zero clears `neg_err_o`.
- R5: If both words carry the symmetric bit, the result is full (3) when the request is code 3 or 4, and receive-only (1) otherwise.
- R6: If the local word has the asymmetric bit but not the symmetric bit, and the partner word has both bits, the result is transmit-only (2).
- R7: If the local word has both bits, and the partner word has the asymmetric bit but not the symmetric bit, the result is receive-only (1).
- R8: Every other combination of non-zero words resolves to none (0).
- R9: `mode_o` uses 0 none, 1 receive, 2 transmit, 3 full. `rx_pause_en_o` equals bit 0 of the mode and `tx_pause_en_o` equals bit 1.
- R10: The result is registered on the clock edge where `resolve_i` is high, one cycle of latency. It holds while `resolve_i` is low. Reset gives mode none and `neg_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_mode_i | input | 3 | Requested pause mode code |
| strict_i | input | 1 | Strict-standard flag; forbids a receive-only request |
| resolve_i | input | 1 | Strobe that registers a new resolution |
| local_adv_i | input | ADV_W | Local advertisement word |
| lp_adv_i | input | ADV_W | Link-partner advertisement word |
| adv_sym_o | output | 1 | Symmetric pause bit to advertise |
| adv_asm_o | output | 1 | Asymmetric pause bit to advertise |
| req_err_o | output | 1 | Request invalid |
| mode_o | output | 2 | Resolved mode |
| rx_pause_en_o | output | 1 | Receive-pause handling enable |
| tx_pause_en_o | output | 1 | Transmit-pause generation enable |
| neg_err_o | output | 1 | Last resolve failed |

## Verification
The bench builds the block with 4-bit advertisement words, the symmetric bit at position 2 and the asymmetric bit at position 3. This leaves two ordinary bits in each word, so non-zero words with no pause bits can occur. With words this narrow, every pair of words is swept against all eight request codes. That sweep covers every resolution branch, the zero-word failure on either side and the invalid codes. The mode held across failures and idle cycles is followed from one strobe to the next, so the hold behaviour is checked against a running expected value.

// File: rtl/pause_res_pkg.sv
package pause_res_pkg;
  localparam logic [2:0] REQ_NONE = 3'd0;
  localparam logic [2:0] REQ_RX   = 3'd1;
  localparam logic [2:0] REQ_TX   = 3'd2;
  localparam logic [2:0] REQ_FULL = 3'd3;
  localparam logic [2:0] REQ_DFLT = 3'd4;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_RX   = 2'd1;
  localparam logic [1:0] MODE_TX   = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;

  typedef struct packed {
    logic       fail;
    logic [1:0] mode;
  } res_t;
endpackage

// File: rtl/pause_adv_enc.sv
module pause_adv_enc
  import pause_res_pkg::*;
(
  input  logic [2:0] req_i,
  input  logic       strict_i,
  output logic       adv_sym_o,
  output logic       adv_asm_o,
  output logic       req_err_o,
  output logic       req_full_o
);
  always_comb begin
    adv_sym_o  = 1'b0;
    adv_asm_o  = 1'b0;
    req_err_o  = 1'b0;
    req_full_o = 1'b0;
    unique case (req_i)
      REQ_NONE: ;
      REQ_TX:   adv_asm_o = 1'b1;
      REQ_RX: begin
        if (strict_i) req_err_o = 1'b1;
        else begin
          adv_sym_o = 1'b1;
          adv_asm_o = 1'b1;
        end
      end
      REQ_FULL, REQ_DFLT: begin
        adv_sym_o  = 1'b1;
        adv_asm_o  = 1'b1;
        req_full_o = 1'b1;
      end
      default: req_err_o = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({req_i, strict_i})) begin
      assert_sym_needs_asm_R1: assert (!(adv_sym_o && !adv_asm_o));
      assert_err_silent_R2: assert (!(req_err_o && (adv_sym_o || adv_asm_o)));
    end
  end
endmodule

// File: rtl/pause_resolve_core.sv
module pause_resolve_core
  import pause_res_pkg::*;
#(
  parameter int ADV_W   = 8,
  parameter int SYM_POS = 0,
  parameter int ASM_POS = 1
) (
  input  logic [ADV_W-1:0] local_adv_i,
  input  logic [ADV_W-1:0] lp_adv_i,
  input  logic             req_full_i,
  output res_t             res_o
);
  logic l_sym, l_asm, p_sym, p_asm;

  assign l_sym = local_adv_i[SYM_POS];
  assign l_asm = local_adv_i[ASM_POS];
  assign p_sym = lp_adv_i[SYM_POS];
  assign p_asm = lp_adv_i[ASM_POS];

  always_comb begin
    res_o.fail = (local_adv_i == '0) || (lp_adv_i == '0);
    if (res_o.fail)                          res_o.mode = MODE_NONE;
    else if (l_sym && p_sym)                 res_o.mode = req_full_i ? MODE_FULL : MODE_RX;
    else if (!l_sym && l_asm && p_sym && p_asm) res_o.mode = MODE_TX;
    else if (l_sym && l_asm && !p_sym && p_asm)  res_o.mode = MODE_RX;
    else                                     res_o.mode = MODE_NONE;
  end

  always_comb begin
    if (!$isunknown({local_adv_i, lp_adv_i, req_full_i})) begin
      assert_tx_local_asym_R6: assert (!(res_o.mode == MODE_TX && l_sym));
    end
  end
endmodule

// File: rtl/pause_mode_reg.sv
module pause_mode_reg
  import pause_res_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  res_t       res_i,
  output logic [1:0] mode_o,
  output logic       neg_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= MODE_NONE;
      neg_err_o <= 1'b0;
    end else if (load_i) begin
      neg_err_o <= res_i.fail;
      if (!res_i.fail) mode_o <= res_i.mode;
    end
  end

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_o) && $stable(neg_err_o));
  assert_fail_keeps_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && res_i.fail |=> neg_err_o && $stable(mode_o));
endmodule

// File: rtl/pause_resolver.sv
module pause_resolver
  import pause_res_pkg::*;
#(
  parameter int ADV_W   = 8,
  parameter int SYM_POS = 0,
  parameter int ASM_POS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       req_mode_i,
  input  logic             strict_i,
  input  logic             resolve_i,
  input  logic [ADV_W-1:0] local_adv_i,
  input  logic [ADV_W-1:0] lp_adv_i,
  output logic             adv_sym_o,
  output logic             adv_asm_o,
  output logic             req_err_o,
  output logic [1:0]       mode_o,
  output logic             rx_pause_en_o,
  output logic             tx_pause_en_o,
  output logic             neg_err_o
);
  logic req_full;
  res_t res;

  pause_adv_enc u_enc (
    .req_i      (req_mode_i),
    .strict_i   (strict_i),
    .adv_sym_o  (adv_sym_o),
    .adv_asm_o  (adv_asm_o),
    .req_err_o  (req_err_o),
    .req_full_o (req_full)
  );

  pause_resolve_core #(.ADV_W(ADV_W), .SYM_POS(SYM_POS), .ASM_POS(ASM_POS)) u_core (
    .local_adv_i (local_adv_i),
    .lp_adv_i    (lp_adv_i),
    .req_full_i  (req_full),
    .res_o       (res)
  );

  pause_mode_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (resolve_i),
    .res_i     (res),
    .mode_o    (mode_o),
    .neg_err_o (neg_err_o)
  );

  assign rx_pause_en_o = mode_o[0];
  assign tx_pause_en_o = mode_o[1];

  assert_full_needs_full_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && (local_adv_i != '0) && (lp_adv_i != '0) &&
    (req_mode_i != REQ_FULL) && (req_mode_i != REQ_DFLT) |=> mode_o != MODE_FULL);
  assert_enables_track_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && !neg_err_o |=> (rx_pause_en_o || tx_pause_en_o) == (mode_o != MODE_NONE));
endmodule

// File: tb/pause_resolver_test.sv
module pause_resolver_test;
  localparam int W = 4, SP = 2, AP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req = '0;
  logic strict = 1'b0, resolve = 1'b0;
  logic [W-1:0] la = '0, lp = '0;
  logic a_sym, a_asm, r_err, rx_en, tx_en, n_err;
  logic [1:0] mode;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pause_resolver #(.ADV_W(W), .SYM_POS(SP), .ASM_POS(AP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_mode_i(req), .strict_i(strict),
    .resolve_i(resolve), .local_adv_i(la), .lp_adv_i(lp),
    .adv_sym_o(a_sym), .adv_asm_o(a_asm), .req_err_o(r_err),
    .mode_o(mode), .rx_pause_en_o(rx_en), .tx_pause_en_o(tx_en), .neg_err_o(n_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected {fail, mode} from requirements R4..R8
  function automatic logic [2:0] model(input logic [W-1:0] l, input logic [W-1:0] p,
                                       input logic [2:0] r);
    logic full;
    full = (r == 3'd3) || (r == 3'd4);
    if (l == 0 || p == 0) return {1'b1, 2'd0};
    if (l[SP] && p[SP]) return {1'b0, full ? 2'd3 : 2'd1};
    if (!l[SP] && l[AP] && p[SP] && p[AP]) return {1'b0, 2'd2};
    if (l[SP] && l[AP] && !p[SP] && p[AP]) return {1'b0, 2'd1};
    return {1'b0, 2'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] exp_mode;
    logic [2:0] m;
    logic e_sym, e_asm, e_err;
    exp_mode = 2'd0;
    repeat (3) @(negedge clk);
    chk("R10 reset mode", mode, 0);
    chk("R10 reset neg_err", n_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 advertisement sweep
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 8; r++) begin
        strict = s[0]; req = r[2:0];
        #1;
        e_err = (r > 4) || (r == 1 && s == 1);
        e_asm = !e_err && (r != 0);
        e_sym = !e_err && (r == 1 || r == 3 || r == 4);
        chk("R1 adv_asm", a_asm, e_asm);
        chk("R1 adv_sym", a_sym, e_sym);
        chk(r == 1 ? "R2 req_err" : "R3 req_err", r_err, e_err);
      end
    end
    strict = 1'b0;

    // R4..R10 resolution sweep
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < 16; l++) begin
        for (int p = 0; p < 16; p++) begin
          @(negedge clk);
          req = r[2:0]; la = l[W-1:0]; lp = p[W-1:0]; resolve = 1'b1;
          m = model(la, lp, req);
          if (!m[2]) exp_mode = m[1:0];
          @(negedge clk);
          resolve = 1'b0;
          chk(m[2] ? "R4 neg_err" : "R4 neg_err clear", n_err, m[2]);
          if (m[2]) chk("R4 mode kept", mode, exp_mode);
          else if (la[SP] && lp[SP]) chk("R5 mode", mode, exp_mode);
          else if (exp_mode == 2'd2) chk("R6 mode", mode, exp_mode);
          else if (exp_mode == 2'd1) chk("R7 mode", mode, exp_mode);
          else chk("R8 mode", mode, exp_mode);
          chk("R9 rx_en", rx_en, exp_mode[0]);
          chk("R9 tx_en", tx_en, exp_mode[1]);
          la = ~la; lp = ~lp; req = ~req;
          @(negedge clk);
          chk("R10 hold mode", mode, exp_mode);
          chk("R10 hold neg_err", n_err, m[2]);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule